// File: doc/BRIEF.md
# Dual Gated Retriggerable One-Shot Timer

This block provides two independent clocked one-shot pulse generators. Each channel watches three asynchronous inputs: a trigger that fires on a falling edge, a trigger that fires on a rising edge, and an active-low clear. Each trigger is gated by the level of the other trigger and by the clear. A valid event loads a per-channel cycle count and drives the output high for that many clock cycles plus one. The clear has two roles. Pulling it low kills the output at once. Raising it fires a new pulse when both trigger gates are open.

If a valid event arrives while a pulse is running, the full period starts again. A trigger train that repeats faster than the period therefore holds the output high without a gap. Every output has a complementary partner. The pulse length is a runtime value on a 16-bit port and needs no external timing parts.

Top module: `mono_timer_dual`

## Requirements
- R1: After reset, q_o is low and qn_o is high on both channels.
- R2: While clr_ni of a channel is low, that channel's q_o is low and qn_o is high in the same cycle. This holds whatever a_i and b_i do.
- R3: A falling edge on a_i fires the channel when b_i is high and clr_ni is high.
- R4: A rising edge on b_i fires the channel when a_i is low and clr_ni is high.
- R5: A rising edge on clr_ni fires the channel when a_i is low and b_i is high.
- R6: No pulse starts in these cases: a falling edge on a_i while b_i is low, a rising edge on b_i while a_i is high, or a rising edge on clr_ni while a_i is high.
- R7: An input change made at one falling clock edge shows as q_o high at the third following falling edge. q_o then stays high for count+1 cycles, so a count of 0 gives a one-cycle pulse.
- R8: A valid event during an active pulse restarts the full period. The pulse then ends count+1 cycles after that event takes effect, and a trigger train faster than the period keeps q_o high continuously.
- R9: A pulse cut short by clr_ni low does not resume when clr_ni returns high without a valid event.
- R10: count_i is sampled only in the cycle a pulse is fired. Changing it during the pulse does not change that pulse's length.
- R11: qn_o is always the complement of q_o.
- R12: The channels are independent. A pulse on one channel leaves the other channel's q_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | NCH | Falling-edge trigger, one bit per channel (asynchronous) |
| b_i | input | NCH | Rising-edge trigger, one bit per channel (asynchronous) |
| clr_ni | input | NCH | Active-low clear and rising-edge trigger, one bit per channel |
| count_i | input | NCH*CW | Pulse length minus one per channel; channel c uses bits [c*CW +: CW] |
| q_o | output | NCH | Pulse output |
| qn_o | output | NCH | Complement of q_o |

## Verification
The bench changes inputs just after a falling clock edge and samples on later falling edges. A trigger passes two synchroniser flops, one edge-compare stage and the pulse register, so its first high sample is due on the third falling edge after the change. The pulse must then read high on exactly count+1 consecutive samples. A clear reaches the output with no register in the path, so its effect is checked at the very next sample. A retrigger moves the expected end to count+1 cycles after the retrigger takes effect, and the bench counts the high samples inside that window.

// File: rtl/mono_timer_pkg.sv
package mono_timer_pkg;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic a;
    logic b;
    logic clr;
  } trig_in_t;

  // inert values: a high blocks every trigger, clear released
  localparam trig_in_t TRIG_IDLE = '{a: 1'b1, b: 1'b0, clr: 1'b1};
endpackage

// File: rtl/mono_sync.sv
module mono_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mono_trig_detect.sv
module mono_trig_detect
  import mono_timer_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  trig_in_t s_i,
  output logic     fire_o,
  output logic     clr_o
);
  trig_in_t prev_q;
  logic     a_fall, b_rise, c_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= TRIG_IDLE;
    else         prev_q <= s_i;
  end

  // each edge is gated by the levels of the other two inputs
  assign a_fall = prev_q.a & ~s_i.a &  s_i.b & s_i.clr;
  assign b_rise = ~prev_q.b & s_i.b & ~s_i.a & s_i.clr;
  assign c_rise = ~prev_q.clr & s_i.clr & ~s_i.a & s_i.b;

  assign fire_o = a_fall | b_rise | c_rise;
  assign clr_o  = s_i.clr;
endmodule

// File: rtl/mono_pulse_timer.sv
module mono_pulse_timer #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          clr_i,
  input  logic [CW-1:0] count_i,
  output logic          active_o
);
  logic [CW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!clr_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (fire_i) begin
      // fire or refire: full period restarts from the sampled count
      active_q <= 1'b1;
      cnt_q    <= count_i;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/mono_timer_dual.sv
module mono_timer_dual
  import mono_timer_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    a_i,
  input  logic [NCH-1:0]    b_i,
  input  logic [NCH-1:0]    clr_ni,
  input  logic [NCH*CW-1:0] count_i,
  output logic [NCH-1:0]    q_o,
  output logic [NCH-1:0]    qn_o
);
  localparam int TW = $bits(trig_in_t);

  logic [NCH-1:0] fire_w;
  logic [NCH-1:0] active_w;
  logic [NCH-1:0] clr_s_w;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    trig_in_t raw, syn;

    assign raw = '{a: a_i[c], b: b_i[c], clr: clr_ni[c]};

    mono_sync #(
      .W      (TW),
      .STAGES (SYNC_STAGES),
      .RST_VAL(TRIG_IDLE)
    ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw),
      .q_o   (syn)
    );

    mono_trig_detect u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .s_i   (syn),
      .fire_o(fire_w[c]),
      .clr_o (clr_s_w[c])
    );

    mono_pulse_timer #(.CW(CW)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (fire_w[c]),
      .clr_i   (clr_s_w[c]),
      .count_i (count_i[c*CW +: CW]),
      .active_o(active_w[c])
    );

    // raw clear masks the output without synchroniser delay
    assign q_o[c]  = active_w[c] & clr_ni[c];
    assign qn_o[c] = ~active_w[c] | ~clr_ni[c];
  end
endmodule

// File: rtl/mono_timer_dual_chk.sv
module mono_timer_dual_chk #(
  parameter int NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] clr_ni,
  input logic [NCH-1:0] q_o,
  input logic [NCH-1:0] qn_o,
  input logic [NCH-1:0] fire_i,
  input logic [NCH-1:0] active_i
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R2
    clear_forces_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_ni[c] |-> !q_o[c]);

    // R11
    complement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      qn_o[c] == !q_o[c]);

    // R3 R4 R5 R8
    fire_starts_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i[c] |=> active_i[c]);

    // R6
    no_rise_without_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(active_i[c]) |-> $past(fire_i[c]));

    // R7
    no_end_on_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(active_i[c]) |-> !$past(fire_i[c]));
  end
endmodule

bind mono_timer_dual mono_timer_dual_chk #(.NCH(NCH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_ni  (clr_ni),
  .q_o     (q_o),
  .qn_o    (qn_o),
  .fire_i  (fire_w),
  .active_i(active_w)
);

// File: tb/mono_timer_dual_tb.sv
module mono_timer_dual_tb;
  localparam int NCH = 2;
  localparam int CW  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    a = '1, b = '0, clr = '1;
  logic [NCH*CW-1:0] cnt = '0;
  logic [NCH-1:0]    q, qn;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mono_timer_dual #(.NCH(NCH), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .clr_ni(clr),
    .count_i(cnt), .q_o(q), .qn_o(qn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_cnt(input int ch, input int n);
    cnt[ch*CW +: CW] = n[CW-1:0];
  endtask

  // each fire task leaves the trigger change driven at the current falling edge
  task automatic fire_a(input int ch);
    a[ch] = 1'b1; tick();
    b[ch] = 1'b1; clr[ch] = 1'b1; tick(4);
    a[ch] = 1'b0;
  endtask

  task automatic fire_b(input int ch);
    a[ch] = 1'b1; b[ch] = 1'b0; clr[ch] = 1'b1; tick();
    a[ch] = 1'b0; tick(4);
    b[ch] = 1'b1;
  endtask

  task automatic fire_c(input int ch);
    a[ch] = 1'b1; clr[ch] = 1'b0; tick(4);
    b[ch] = 1'b1; a[ch] = 1'b0; tick(4);
    clr[ch] = 1'b1;
  endtask

  task automatic measure(input int ch, input int n, input string req);
    int first = -1, highs = 0, other = 0, bad_c = 0;
    for (int i = 1; i <= n + 7; i++) begin
      tick();
      if (q[ch]) begin
        highs++;
        if (first < 0) first = i;
      end
      if (q[1-ch]) other++;
      if (qn !== ~q) bad_c++;
    end
    chk(first == 3, "R7", "start latency", first, 3);
    chk(highs == n + 1, req, "pulse width", highs, n + 1);
    chk(other == 0, "R12", "other channel high samples", other, 0);
    chk(bad_c == 0, "R11", "complement mismatches", bad_c, 0);
  endtask

  task automatic watch_low(input int ch, input int n, input string req, input string what);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (q[ch]) highs++;
    end
    chk(highs == 0, req, what, highs, 0);
  endtask

  initial begin
    int lens[5] = '{0, 1, 2, 5, 9};
    tick(3);
    chk(q == '0, "R1", "q after reset", q, 0);
    chk(qn == '1, "R1", "qn after reset", qn, 3);
    rst_n = 1'b1;
    tick(3);
    chk(q == '0 && qn == '1, "R1", "idle after release", q, 0);

    // sweep: channel x trigger source x length
    for (int ch = 0; ch < NCH; ch++)
      for (int ty = 0; ty < 3; ty++)
        for (int k = 0; k < 5; k++) begin
          set_cnt(ch, lens[k]);
          case (ty)
            0: begin fire_a(ch); measure(ch, lens[k], "R3"); end
            1: begin fire_b(ch); measure(ch, lens[k], "R4"); end
            default: begin fire_c(ch); measure(ch, lens[k], "R5"); end
          endcase
        end

    // R6 gating
    set_cnt(0, 3);
    a[0] = 1'b1; b[0] = 1'b0; clr[0] = 1'b1; tick(4);
    a[0] = 1'b0;
    watch_low(0, 8, "R6", "a fall with b low");
    a[0] = 1'b1; tick(4);
    b[0] = 1'b1;
    watch_low(0, 8, "R6", "b rise with a high");
    clr[0] = 1'b0; tick(4);
    clr[0] = 1'b1;
    watch_low(0, 8, "R6", "clr rise with a high");

    // R8 single retrigger: refire 4 cycles after first fire, count 6
    set_cnt(0, 6);
    fire_a(0); tick(2);
    a[0] = 1'b1; tick(2);
    a[0] = 1'b0;
    begin
      int highs = 0, last = 0;
      for (int i = 1; i <= 12; i++) begin
        tick();
        if (q[0]) begin highs++; last = i; end
      end
      chk(highs == 9, "R8", "high samples after retrigger", highs, 9);
      chk(last == 9, "R8", "last high sample", last, 9);
    end

    // R8 trigger train every 4 cycles holds q high
    set_cnt(1, 6);
    fire_a(1); tick(3);
    begin
      int lows = 0;
      for (int r = 0; r < 10; r++) begin
        a[1] = 1'b1; tick(); if (!q[1]) lows++;
        tick(); if (!q[1]) lows++;
        a[1] = 1'b0; tick(); if (!q[1]) lows++;
        tick(); if (!q[1]) lows++;
      end
      chk(lows == 0, "R8", "low samples during train", lows, 0);
    end
    tick(12);

    // R2 and R9: cut a long pulse short
    set_cnt(1, 20);
    fire_a(1); tick(6);
    chk(q[1] == 1'b1, "R9", "pulse running before clear", q[1], 1);
    a[1] = 1'b1; clr[1] = 1'b0;
    tick();
    chk(q[1] == 1'b0 && qn[1] == 1'b1, "R2", "q on clear", q[1], 0);
    begin
      int highs = 0;
      for (int i = 0; i < 6; i++) begin
        a[1] = ~a[1]; b[1] = ~b[1];
        tick();
        if (q[1] || !qn[1]) highs++;
      end
      chk(highs == 0, "R2", "q high while clear low", highs, 0);
    end
    a[1] = 1'b1; b[1] = 1'b1; tick();
    clr[1] = 1'b1;
    watch_low(1, 25, "R9", "pulse resumed after clear");

    // R10 count changed after the fire edge
    set_cnt(0, 3);
    fire_b(0); tick(3);
    chk(q[0] == 1'b1, "R10", "pulse started", q[0], 1);
    set_cnt(0, 40);
    begin
      int highs = 0;
      for (int i = 0; i < 10; i++) begin
        tick();
        if (q[0]) highs++;
      end
      chk(highs == 3, "R10", "remaining high samples", highs, 3);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule